// File: doc/BRIEF.md
# Multicast Hash Table Filter

This block decides whether the destination address of an incoming frame belongs to a multicast group that the receiver has joined. A 12-bit index is cut straight out of the upper two bytes of the 48-bit destination address. There is no CRC. A 2-bit window mode chooses which bits form the index, and so which addresses collide. The index points at one bit of a 4096-bit table, and that bit is the accept decision. Software fills the table through a word-wide register port. It sets the window mode once, at initialisation, and uses the same mode when it works out which table bits to set.

A lookup request with a valid strobe gives a registered accept result and a result strobe one clock later. The control sequencer has two states:

- `ST_SWEEP`: walks the table one word per cycle and writes zeros. It is entered at reset, and again whenever the synchronous clear input is seen in `ST_SERVE`. A clear that arrives while sweeping restarts the walk at word 0.
- `ST_SERVE`: register writes and lookups are accepted. The sequencer moves from `ST_SWEEP` to `ST_SERVE` when the walk finishes its last word.

While the sweep runs, lookups give no result and register writes have no effect.

Top module: `mcast_hash_filter`

## Requirements
- R1: Address byte k (k = 1..6, in receive order) sits on `lk_addr_i[8k-1:8k-8]`, so the fifth byte is bits [39:32] and the sixth is [47:40]. The index is taken as follows:
  - mode 0: bits [47:36]
  - mode 1: bits [46:35]
  - mode 2: bits [45:34]
  - mode 3: bits [43:32]
- R2: The table is 128 words of 32 bits. Index bits [11:5] select the word and bits [4:0] select the bit, and a lookup reports exactly that bit. Bits next to it in the same word have no effect on the result.
- R3: When `reg_we_i` is high in `ST_SERVE`, `reg_wdata_i` is stored in the word at `reg_addr_i`. `reg_rdata_o` shows the word addressed at the previous clock edge.
- R4: When bit 0 of the first address byte (`lk_addr_i[0]`, the group bit) is 0, the result is reject, whatever the table holds.
- R5: `res_valid_o` is high exactly one clock after `lk_valid_i` is sampled high in `ST_SERVE`, and is never high otherwise.
- R6: After a clear pulse, all 4096 table bits are zero, and lookups give no result, for the next 128 clock edges. A lookup sampled at the edge after those 128 edges gives a result.
- R7: When a register write and a lookup that reads the same word happen in the same cycle, the lookup returns the contents from before the write.
- R8: After reset, `res_valid_o` and `reg_rdata_o` are 0. The table is swept to zero before any lookup is served.
- R9: Register writes issued while the sweep is running are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous request to zero the whole table |
| mode_i | input | 2 | Index window mode, 0..3 |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 7 | Table word address for both write and read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_addr_i | input | 48 | Destination address to look up |
| res_valid_o | output | 1 | Lookup result strobe |
| res_accept_o | output | 1 | 1 = address accepted |

## Verification
The hardest case to reach from the ports is the exact boundary at which a sweep ends. The stimulus raises `lk_valid_i` on the cycle right after the clear pulse and holds it high without a break. It checks that no result appears for 128 edges and that one appears at the next edge. Register writes placed inside that window are read back as zero afterwards. Each window mode is tested by setting a single bit and then its 31 neighbours in the same word, so that a wrong index can be seen even when it falls in the right word.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    typedef enum logic [1:0] {
        WIN_TOP    = 2'd0,
        WIN_TOP_M1 = 2'd1,
        WIN_TOP_M2 = 2'd2,
        WIN_TOP_M4 = 2'd3
    } win_mode_e;

    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_SERVE = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/mcf_index_sel.sv
module mcf_index_sel
    import mcf_pkg::*;
#(
    parameter int IDX_W = 12,
    localparam int SRC_W = IDX_W + 4
) (
    input  win_mode_e          mode_i,
    input  logic [SRC_W-1:0]   src_i,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        idx_o = '0;
        unique case (mode_i)
            WIN_TOP:    idx_o = src_i[SRC_W-1 -: IDX_W];
            WIN_TOP_M1: idx_o = src_i[SRC_W-2 -: IDX_W];
            WIN_TOP_M2: idx_o = src_i[SRC_W-3 -: IDX_W];
            WIN_TOP_M4: idx_o = src_i[IDX_W-1:0];
            default:    idx_o = '0;
        endcase
    end

endmodule

// File: rtl/mcf_ctrl.sv
module mcf_ctrl
    import mcf_pkg::*;
#(
    parameter int WADDR_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    output logic               sweep_o,
    output logic               serve_o,
    output logic [WADDR_W-1:0] sweep_word_o
);

    localparam logic [WADDR_W-1:0] CNT_LAST = '1;

    ctrl_state_e        state_q, state_d;
    logic [WADDR_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SERVE: if (clr_i) state_d = ST_SWEEP;
            ST_SWEEP: if (!clr_i && cnt_q == CNT_LAST) state_d = ST_SERVE;
            default:  state_d = ST_SWEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SWEEP && !clr_i)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    always_comb begin
        sweep_o      = 1'b0;
        serve_o      = 1'b0;
        sweep_word_o = cnt_q;
        unique case (state_q)
            ST_SWEEP: sweep_o = 1'b1;
            ST_SERVE: serve_o = !clr_i;
            default:  sweep_o = 1'b1;
        endcase
    end

    AST_SWEEP_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVE && $past(state_q) == ST_SWEEP) |-> $past(cnt_q) == CNT_LAST); // R6

endmodule

// File: rtl/mcf_table.sv
module mcf_table #(
    parameter int IDX_W  = 12,
    parameter int WORD_W = 32,
    localparam int BIT_W   = $clog2(WORD_W),
    localparam int WADDR_W = IDX_W - BIT_W,
    localparam int WORDS   = 1 << WADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sweep_i,
    input  logic [WADDR_W-1:0] sweep_word_i,
    input  logic               we_i,
    input  logic [WADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [WORD_W-1:0]  rdata_o,
    input  logic [IDX_W-1:0]   idx_i,
    output logic               bit_o
);

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (sweep_i)
            mem[sweep_word_i] <= '0;
        else if (we_i)
            mem[addr_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= mem[addr_i];
    end

    assign rdata_o = rd_q;
    assign bit_o   = mem[idx_i[IDX_W-1:BIT_W]][idx_i[BIT_W-1:0]];

    AST_SWEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sweep_i) |-> mem[$past(sweep_word_i)] == '0); // R9

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mcf_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 48,
    localparam int BIT_W   = $clog2(WORD_W),
    localparam int WADDR_W = IDX_W - BIT_W,
    localparam int SRC_W   = IDX_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [1:0]         mode_i,
    input  logic               reg_we_i,
    input  logic [WADDR_W-1:0] reg_addr_i,
    input  logic [WORD_W-1:0]  reg_wdata_i,
    output logic [WORD_W-1:0]  reg_rdata_o,
    input  logic               lk_valid_i,
    input  logic [ADDR_W-1:0]  lk_addr_i,
    output logic               res_valid_o,
    output logic               res_accept_o
);

    logic               sweep, serve;
    logic [WADDR_W-1:0] sweep_word;
    logic [IDX_W-1:0]   idx;
    logic               tbl_bit;
    logic               res_valid_q, res_accept_q;
    logic               addr_unused;

    assign addr_unused = ^lk_addr_i[ADDR_W-SRC_W-1:1];

    mcf_ctrl #(.WADDR_W(WADDR_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_i),
        .sweep_o      (sweep),
        .serve_o      (serve),
        .sweep_word_o (sweep_word)
    );

    mcf_index_sel #(.IDX_W(IDX_W)) i_idx (
        .mode_i (win_mode_e'(mode_i)),
        .src_i  (lk_addr_i[ADDR_W-1 -: SRC_W]),
        .idx_o  (idx)
    );

    mcf_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) i_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sweep_i      (sweep),
        .sweep_word_i (sweep_word),
        .we_i         (reg_we_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .rdata_o      (reg_rdata_o),
        .idx_i        (idx),
        .bit_o        (tbl_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid_q  <= 1'b0;
            res_accept_q <= 1'b0;
        end else begin
            res_valid_q  <= lk_valid_i && serve;
            res_accept_q <= lk_addr_i[0] && tbl_bit;
        end
    end

    assign res_valid_o  = res_valid_q;
    assign res_accept_o = res_accept_q;

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(lk_valid_i)); // R5
    AST_NO_RESULT_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sweep) |-> !res_valid_o); // R6
    AST_UNICAST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !$past(lk_addr_i[0])) |-> !res_accept_o); // R4

endmodule

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        reg_we_i = 1'b0;
    logic [6:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        lk_valid_i = 1'b0;
    logic [47:0] lk_addr_i = '0;
    logic        res_valid_o;
    logic        res_accept_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    mcast_hash_filter i_mcast_hash_filter (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mode_i(mode_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
        .res_valid_o(res_valid_o), .res_accept_o(res_accept_o)
    );

    // {mode, address, expected index, expected accept}
    localparam int NV = 9;
    localparam logic [62:0] VEC [NV] = '{
        {2'd0, 48'hA5C3_0000_0001, 12'hA5C, 1'b1},
        {2'd1, 48'hA5C3_0000_0001, 12'h4B8, 1'b1},
        {2'd2, 48'hA5C3_0000_0001, 12'h970, 1'b1},
        {2'd3, 48'hA5C3_0000_0001, 12'h5C3, 1'b1},
        {2'd0, 48'hFFF0_1234_5677, 12'hFFF, 1'b1},
        {2'd3, 48'h0000_9ABC_DEF1, 12'h000, 1'b1},
        {2'd1, 48'h8008_0000_0003, 12'h001, 1'b1},
        {2'd2, 48'h1234_0000_0001, 12'h48D, 1'b1},
        {2'd0, 48'hA5C3_0000_0002, 12'hA5C, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a;
        @(negedge clk);
        d = reg_rdata_o;
    endtask

    task automatic look(input logic [1:0] m, input logic [47:0] a, output logic v, output logic acc);
        @(negedge clk);
        mode_i = m; lk_addr_i = a; lk_valid_i = 1'b1;
        @(negedge clk);
        lk_valid_i = 1'b0;
        v = res_valid_o; acc = res_accept_o;
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic v, acc;
        logic [31:0] d;
        int hits;

        // R8: reset state
        repeat (3) @(negedge clk);
        check(res_valid_o == 1'b0 && reg_rdata_o == '0, "R8 reset outputs", {reg_rdata_o, 31'd0, res_valid_o}, 64'd0);
        rst_n = 1'b1;
        look(2'd0, 48'hA5C3_0000_0001, v, acc);
        check(v == 1'b0, "R8 no lookup during initial sweep", v, 0);
        repeat (140) @(negedge clk);
        rd(7'd5, d);
        check(d == '0, "R8 table zero after reset", d, 0);

        // R1/R2/R4 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [11:0] ix;
            ix = VEC[i][12:1];
            wr(ix[11:5], 32'h1 << ix[4:0]);
            look(VEC[i][62:61], VEC[i][60:13], v, acc);
            check(v == 1'b1 && acc == VEC[i][0], "R1/R4 vector accept", {v, acc}, {1'b1, VEC[i][0]});
            wr(ix[11:5], ~(32'h1 << ix[4:0]));
            look(VEC[i][62:61], VEC[i][60:13], v, acc);
            check(v == 1'b1 && acc == 1'b0, "R2 neighbour bits ignored", {v, acc}, 2'b10);
            wr(ix[11:5], 32'h0);
        end

        // R5: no result without request
        @(negedge clk);
        check(res_valid_o == 1'b0, "R5 idle no result", res_valid_o, 0);

        // R3: write then read back
        wr(7'd10, 32'hDEAD_BEEF);
        rd(7'd10, d);
        check(d == 32'hDEAD_BEEF, "R3 readback", d, 32'hDEAD_BEEF);

        // R7: write and lookup same word same cycle -> old contents
        wr(7'h52, 32'h0);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = 7'h52; reg_wdata_i = 32'h1000_0000;
        mode_i = 2'd0; lk_addr_i = 48'hA5C3_0000_0001; lk_valid_i = 1'b1;
        @(negedge clk);
        reg_we_i = 1'b0; lk_valid_i = 1'b0;
        check(res_valid_o == 1'b1 && res_accept_o == 1'b0, "R7 old contents seen", {res_valid_o, res_accept_o}, 2'b10);
        look(2'd0, 48'hA5C3_0000_0001, v, acc);
        check(acc == 1'b1, "R7 new contents after write", acc, 1);

        // R6/R9: clear sweep window
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        lk_valid_i = 1'b1; mode_i = 2'd0; lk_addr_i = 48'hA5C3_0000_0001;
        reg_we_i = 1'b1; reg_addr_i = 7'd20; reg_wdata_i = 32'hFFFF_FFFF;
        hits = 0;
        for (int k = 0; k < 128; k++) begin
            @(negedge clk);
            if (k == 2) reg_we_i = 1'b0;
            if (k == 126) begin reg_we_i = 1'b1; reg_addr_i = 7'd0; end
            if (res_valid_o) hits++;
        end
        reg_we_i = 1'b0;
        check(hits == 0, "R6 no result during sweep", hits, 0);
        @(negedge clk);
        lk_valid_i = 1'b0;
        check(res_valid_o == 1'b1 && res_accept_o == 1'b0, "R6 served after 128 edges, bit cleared", {res_valid_o, res_accept_o}, 2'b10);
        rd(7'd20, d);
        check(d == '0, "R9 write during sweep dropped", d, 0);
        rd(7'd0, d);
        check(d == '0, "R9 late write during sweep dropped", d, 0);
        rd(7'd10, d);
        check(d == '0, "R6 earlier word cleared", d, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule